// File: doc/BRIEF.md
# Four-Bit Multi-Function Register

This block is a small clocked register whose next contents are chosen on every rising clock edge by a two-bit operation code. It can keep its value, take a new value from a parallel data input, return to zero, or count up by one. It has no reset pin. A clear operation supplies the zero value by steering a constant zero through the same per-bit next-value selector that carries the load data. The flip-flops have no clear pin of their own.

Each stored bit has its own flip-flop and its own next-value selector. The increment path uses a ripple carry chain that starts at one, so the incremented value wraps from all ones to all zeros and no carry leaves the block. The output is taken directly from the flip-flops. The width is a parameter with a default of four bits. The contents at power-up are undefined until the first load or clear.

Top module: `multi_func_reg`

## Requirements
- R1: With opSel = 2'b00 (hold), the value on q after the rising edge equals the value before it.
- R2: With opSel = 2'b01 (load), q takes the value of dataIn on the rising edge.
- R3: With opSel = 2'b10 (clear), q becomes all zeros on the rising edge, whatever its previous contents.
- R4: With opSel = 2'b11 (increment), q becomes its previous value plus one on the rising edge.
- R5: An increment applied while q is all ones (4'b1111 at default width) gives all zeros, with no carry output.
- R6: During a clear, dataIn has no effect: q is zero after the edge for any dataIn value.
- R7: q changes only at a rising clock edge. Changes on opSel or dataIn between edges do not show on q.
- R8: During a hold, dataIn has no effect: q keeps its value for any dataIn value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| dataIn | input | WIDTH (4) | Parallel load value |
| opSel | input | 2 | Operation: 00 hold, 01 load, 10 clear, 11 increment |
| q | output | WIDTH (4) | Stored value, driven directly by the flip-flops |

## Verification
The register has no reset, so the assertions stay disabled until the first load or clear has set the contents. After that point they assume that opSel and dataIn are stable around each rising edge. The stimulus starts with a clear and changes the inputs only on the falling edge. The one exception is the mid-cycle test for R7, which moves dataIn and opSel while the clock is low and puts them back before the next rising edge.

// File: rtl/mfreg_pkg.sv
`timescale 1ns/1ps
package mfreg_pkg;

  typedef enum logic [1:0] {
    OP_HOLD  = 2'b00,
    OP_LOAD  = 2'b01,
    OP_CLEAR = 2'b10,
    OP_INCR  = 2'b11
  } opCode_t;

  // Strobes passed from control to datapath; hold is the absence of all three.
  typedef struct packed {
    logic takeData;
    logic forceZero;
    logic countUp;
  } regStrobe_t;

endpackage

// File: rtl/mfreg_ctrl.sv
`timescale 1ns/1ps
module mfreg_ctrl
  import mfreg_pkg::*;
(
  input  logic [1:0]  opSel,
  output regStrobe_t  strobes
);

  opCode_t opCode;

  always_comb begin
    opCode = opCode_t'(opSel);
    strobes = '0;
    unique case (opCode)
      OP_HOLD:  strobes = '0;
      OP_LOAD:  strobes.takeData  = 1'b1;
      OP_CLEAR: strobes.forceZero = 1'b1;
      OP_INCR:  strobes.countUp   = 1'b1;
      default:  strobes = '0;
    endcase
  end

endmodule

// File: rtl/mfreg_datapath.sv
`timescale 1ns/1ps
module mfreg_datapath
  import mfreg_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  regStrobe_t       strobes,
  input  logic [WIDTH-1:0] dataIn,
  output logic [WIDTH-1:0] qOut
);

  localparam int CARRY_BITS = WIDTH + 1;

  logic [WIDTH-1:0]      stored;
  logic [WIDTH-1:0]      nextVal;
  logic [CARRY_BITS-1:0] carry;

  // Carry into bit 0 is one: the increment adds exactly one.
  assign carry[0] = 1'b1;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic sumBit;

    assign sumBit     = stored[i] ^ carry[i];
    assign carry[i+1] = stored[i] & carry[i];

    // Per-bit next-value selector; clear routes a constant zero.
    always_comb begin
      if (strobes.forceZero)
        nextVal[i] = 1'b0;
      else if (strobes.takeData)
        nextVal[i] = dataIn[i];
      else if (strobes.countUp)
        nextVal[i] = sumBit;
      else
        nextVal[i] = stored[i];
    end

    always_ff @(posedge clk) begin
      stored[i] <= nextVal[i];
    end
  end

  // Top carry is dropped: wrap from all ones to zero.
  logic unusedCarry;
  assign unusedCarry = carry[WIDTH];

  assign qOut = stored;

endmodule

// File: rtl/multi_func_reg.sv
`timescale 1ns/1ps
module multi_func_reg
  import mfreg_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] dataIn,
  input  logic [1:0]       opSel,
  output logic [WIDTH-1:0] q
);

  regStrobe_t ctrlStrobes;

  mfreg_ctrl u_ctrl (
    .opSel   (opSel),
    .strobes (ctrlStrobes)
  );

  mfreg_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk     (clk),
    .strobes (ctrlStrobes),
    .dataIn  (dataIn),
    .qOut    (q)
  );

endmodule

// File: rtl/mfreg_chk.sv
`timescale 1ns/1ps
module mfreg_chk
  import mfreg_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic [WIDTH-1:0] dataIn,
  input logic [1:0]       opSel,
  input logic [WIDTH-1:0] q,
  input regStrobe_t       strobes
);

  // Contents are only defined after the first load or clear.
  logic primed = 1'b0;
  always_ff @(posedge clk) begin
    if (opSel == 2'b01 || opSel == 2'b10) primed <= 1'b1;
  end

  p_hold_r1: assert property (@(posedge clk) disable iff (!primed)
    opSel == 2'b00 |=> $stable(q));

  p_load_r2: assert property (@(posedge clk) disable iff (!primed)
    opSel == 2'b01 |=> q == $past(dataIn));

  p_clear_r3: assert property (@(posedge clk) disable iff (!primed)
    opSel == 2'b10 |=> q == '0);

  p_incr_r4: assert property (@(posedge clk) disable iff (!primed)
    opSel == 2'b11 |=> q == WIDTH'($past(q) + 1'b1));

  p_wrap_r5: assert property (@(posedge clk) disable iff (!primed)
    (opSel == 2'b11 && q == '1) |=> q == '0);

  p_strobe_onehot_r3: assert property (@(posedge clk) disable iff (!primed)
    $onehot0({strobes.takeData, strobes.forceZero, strobes.countUp}));

endmodule

bind multi_func_reg mfreg_chk #(.WIDTH(WIDTH)) u_chk (
  .clk     (clk),
  .dataIn  (dataIn),
  .opSel   (opSel),
  .q       (q),
  .strobes (ctrlStrobes)
);

// File: tb/sim_multi_func_reg.sv
`timescale 1ns/1ps
module sim_multi_func_reg;

  localparam int W = 4;

  logic         clk = 1'b0;
  logic [W-1:0] dataIn = '0;
  logic [1:0]   opSel = 2'b10;
  logic [W-1:0] q;

  int compared = 0;
  int mismatched = 0;
  int refQ = 0;

  always #10 clk = ~clk;

  multi_func_reg #(.WIDTH(W)) u0 (
    .clk    (clk),
    .dataIn (dataIn),
    .opSel  (opSel),
    .q      (q)
  );

  task automatic check(input string tag, input int expected);
    compared++;
    if (int'(q) != expected) begin
      mismatched++;
      $display("FAIL %s: q=%0h expected=%0h at %0t", tag, q, expected, $time);
    end
  endtask

  // Drive at falling edge, model the rising edge, compare at next falling edge.
  task automatic doCycle(input logic [1:0] op, input int d, input string tag);
    opSel  = op;
    dataIn = W'(d);
    @(posedge clk);
    case (op)
      2'b00: refQ = refQ;
      2'b01: refQ = d % 16;
      2'b10: refQ = 0;
      default: refQ = (refQ + 1) % 16;
    endcase
    @(negedge clk);
    check(tag, refQ);
  endtask

  initial begin
    #(20 * 100000);
    mismatched++;
    $display("FAIL watchdog: q=%0h expected=done", q);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    @(negedge clk);
    doCycle(2'b10, 4'hA, "R6");          // first clear with nonzero data
    check("R3", 0);
    doCycle(2'b00, 4'hF, "R8");          // hold ignores data
    doCycle(2'b01, 4'h5, "R2");
    doCycle(2'b00, 4'h9, "R1");
    doCycle(2'b00, 4'h0, "R8");
    doCycle(2'b11, 0, "R4");
    doCycle(2'b11, 0, "R4");
    doCycle(2'b01, 4'hE, "R2");
    doCycle(2'b11, 0, "R4");             // 1111
    doCycle(2'b11, 0, "R5");             // wraps to 0000
    doCycle(2'b01, 4'hF, "R2");
    doCycle(2'b10, 4'h3, "R3");          // clear from all ones
    for (int v = 0; v < 16; v++) begin
      doCycle(2'b01, v, "R2");
      doCycle(2'b11, 0, (v == 15) ? "R5" : "R4");
      doCycle(2'b00, 15 - v, "R1");
    end
    for (int k = 0; k < 20; k++) doCycle(2'b11, 0, "R4");
    // Mid-cycle input changes must not reach q before the edge.
    doCycle(2'b01, 4'h6, "R2");
    opSel = 2'b01; dataIn = 4'h9;
    #4 check("R7", 6);
    opSel = 2'b10;
    #3 check("R7", 6);
    opSel = 2'b00; dataIn = 4'h1;
    @(posedge clk);
    @(negedge clk);
    check("R7", 6);
    doCycle(2'b10, 4'h7, "R6");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule